// File: doc/BRIEF.md
# Synthesizer Output Divider and Enable Decoder

This block is the digital back end of a fixed-ratio clock synthesizer. It runs on the VCO-rate clock and divides it down to three output banks and one reference output. Bank A has three single-ended lanes at either one-twentieth or one-tenth of the input rate. Bank B has three single-ended lanes at one quarter of the input rate. Bank C has three complementary pairs at one quarter of the input rate. The reference output always runs at one-twentieth of the input rate.

A 3-bit configuration code picks which lanes of each bank are driven and which rate bank A uses. The code is brought into the clock domain through a two-flop synchronizer. A lane is switched on or off, and bank A changes rate, only while the affected divided clock is low, so no output ever shows a shortened high pulse. Each lane drives a data bit and an output-enable flag. A low flag stands for high impedance.

A synchronous master reset holds every divider at its start point. It drives all single-ended outputs low, drives every pair with the true leg low and the complement leg high, and raises every output-enable flag. All dividers leave reset together, so all outputs first rise on the same clock edge.

Top module: `clk_fanout_divider`

## Requirements
- R1: Every enabled bank B lane and bank C true leg toggles with a high phase of B_HALF input cycles and a period of 2*B_HALF cycles (2 and 4 by default).
- R2: Every enabled bank A lane has a high phase of A_SLOW_HALF cycles (10, period 20) when bank A is slow, and A_FAST_HALF cycles (5, period 10) when it is fast.
- R3: ref_clk always runs with a high phase of REF_HALF cycles (10, period 20), whatever the value of oe_code.
- R4: oe_code, read as {oe_code[2],oe_code[1],oe_code[0]}, selects the enabled lanes and the bank A rate. Lane masks below are bit 2..0, where bit i is lane i. 000: A=001 slow, B=000, C=001. 001: A=001 slow, B=001, C=001. 010: A=011 slow, B=000, C=011. 011: A=111 slow, B=111, C=111. 100: A=001 fast, B=000, C=001. 101: A=011 slow, B=011, C=011. 110: A=011 fast, B=000, C=011. 111: all lanes disabled. A lane whose mask bit is 0 has its oe flag low and its data bit held at 0.
- R5: While rst is high, from the first edge on which it is sampled, every a_clk, b_clk, c_p and ref_clk bit is 0, every c_n bit is 1, and every a_oe, b_oe and c_oe flag is 1.
- R6: Outside reset, every c_n bit equals the inverse of the matching c_p bit on every cycle.
- R7: Any sequence of oe_code changes produces no high pulse other than the lane's full high phase. Bank A pulses are A_FAST_HALF or A_SLOW_HALF cycles. An oe flag changes only on a cycle that follows a low data bit on the same lane.
- R8: After rst is released, all enabled lanes and ref_clk first go high on the second clock edge after the first edge that samples rst low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst | input | 1 | Synchronous active-high master reset |
| oe_code | input | 3 | Asynchronous enable and bank A rate code |
| a_clk | output | 3 | Bank A lane data |
| a_oe | output | 3 | Bank A lane drive flags (0 = high impedance) |
| b_clk | output | 3 | Bank B lane data |
| b_oe | output | 3 | Bank B lane drive flags |
| c_p | output | 3 | Bank C true legs |
| c_n | output | 3 | Bank C complement legs |
| c_oe | output | 3 | Bank C pair drive flags |
| ref_clk | output | 1 | Always-running reference output |

## Verification
The bench builds the block with its default half periods of 2, 5, 10 and 10 cycles. Every period is then at most 20 input cycles, so all eight codes can be swept exhaustively, with each enabled lane measured and each disabled lane watched in a single short run. It also steps through fast back-to-back code changes that catch the dividers at every phase. A pulse-width monitor checks that none of these changes cuts a pulse short. A reset taken in the middle of a run checks both the forced levels and the common first rising edge.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  localparam int unsigned LANES = 3;

  typedef logic [LANES-1:0] lane_mask_t;

  typedef struct packed {
    lane_mask_t a_en;
    logic       a_fast;
    lane_mask_t b_en;
    lane_mask_t c_en;
  } out_plan_t;

  // Decode of the 3-bit enable/rate code into per-bank lane masks.
  function automatic out_plan_t plan_of(input logic [2:0] code);
    out_plan_t p;
    p = '0;
    unique case (code)
      3'b000: begin p.a_en = 3'b001; p.b_en = 3'b000; p.c_en = 3'b001; end
      3'b001: begin p.a_en = 3'b001; p.b_en = 3'b001; p.c_en = 3'b001; end
      3'b010: begin p.a_en = 3'b011; p.b_en = 3'b000; p.c_en = 3'b011; end
      3'b011: begin p.a_en = 3'b111; p.b_en = 3'b111; p.c_en = 3'b111; end
      3'b100: begin p.a_en = 3'b001; p.a_fast = 1'b1; p.c_en = 3'b001; end
      3'b101: begin p.a_en = 3'b011; p.b_en = 3'b011; p.c_en = 3'b011; end
      3'b110: begin p.a_en = 3'b011; p.a_fast = 1'b1; p.c_en = 3'b011; end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/fan_cfg_sync.sv
module fan_cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    stg_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/fan_half_div.sv
module fan_half_div #(
  parameter int unsigned SLOW_H = 10,
  parameter int unsigned FAST_H = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_req_i,
  output logic div_o
);

  localparam int unsigned MAXH = (SLOW_H > FAST_H) ? SLOW_H : FAST_H;
  localparam int unsigned CW   = (MAXH > 1) ? $clog2(MAXH) : 1;
  localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_H - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_H - 1);
  localparam logic [CW-1:0] PRELOAD  = CW'(MAXH - 1);

  logic [CW-1:0] cnt_q;
  logic          div_q;
  logic          fast_q;
  logic [CW-1:0] lim;

  assign lim = fast_q ? LIM_FAST : LIM_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= PRELOAD;
      div_q  <= 1'b0;
      fast_q <= fast_req_i;
    end else begin
      if (cnt_q >= lim) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (!div_q) begin
        fast_q <= fast_req_i;
      end
    end
  end

  assign div_o = div_q;

endmodule

// File: rtl/fan_out_lanes.sv
module fan_out_lanes #(
  parameter int unsigned N    = 3,
  parameter bit          PAIR = 1'b0,
  localparam int unsigned LEGS = PAIR ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_i,
  input  logic [N-1:0]      want_i,
  output logic [N*LEGS-1:0] leg_o,
  output logic [N-1:0]      oe_o
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic en_q;
      logic oe_q;
      logic dat_q;

      // Enable is sampled only while the divided clock is low, including
      // during reset where the divider is held low.
      always_ff @(posedge clk) begin
        if (!div_i) begin
          en_q <= want_i[i];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          oe_q  <= 1'b1;
          dat_q <= 1'b0;
        end else begin
          oe_q  <= en_q;
          dat_q <= div_i & en_q;
        end
      end

      assign oe_o[i]  = oe_q;
      assign leg_o[i] = dat_q;

      if (PAIR) begin : g_inv
        logic inv_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            inv_q <= 1'b1;
          end else begin
            inv_q <= ~(div_i & en_q);
          end
        end
        assign leg_o[N+i] = inv_q;
      end
    end
  endgenerate

endmodule

// File: rtl/clk_fanout_divider.sv
module clk_fanout_divider
  import clk_fanout_pkg::*;
#(
  parameter int unsigned B_HALF      = 2,
  parameter int unsigned A_FAST_HALF = 5,
  parameter int unsigned A_SLOW_HALF = 10,
  parameter int unsigned REF_HALF    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       oe_code,
  output logic [LANES-1:0] a_clk,
  output logic [LANES-1:0] a_oe,
  output logic [LANES-1:0] b_clk,
  output logic [LANES-1:0] b_oe,
  output logic [LANES-1:0] c_p,
  output logic [LANES-1:0] c_n,
  output logic [LANES-1:0] c_oe,
  output logic             ref_clk
);

  logic [2:0] code_s;
  out_plan_t  plan;
  logic       div_a;
  logic       div_b;
  logic       div_ref;
  logic       ref_q;

  fan_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (oe_code),
    .q_o (code_s)
  );

  assign plan = plan_of(code_s);

  fan_half_div #(.SLOW_H(A_SLOW_HALF), .FAST_H(A_FAST_HALF)) u_div_a (
    .clk        (clk),
    .rst        (rst),
    .fast_req_i (plan.a_fast),
    .div_o      (div_a)
  );

  fan_half_div #(.SLOW_H(B_HALF), .FAST_H(B_HALF)) u_div_b (
    .clk        (clk),
    .rst        (rst),
    .fast_req_i (1'b0),
    .div_o      (div_b)
  );

  fan_half_div #(.SLOW_H(REF_HALF), .FAST_H(REF_HALF)) u_div_ref (
    .clk        (clk),
    .rst        (rst),
    .fast_req_i (1'b0),
    .div_o      (div_ref)
  );

  fan_out_lanes #(.N(LANES), .PAIR(1'b0)) u_lanes_a (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_a),
    .want_i (plan.a_en),
    .leg_o  (a_clk),
    .oe_o   (a_oe)
  );

  fan_out_lanes #(.N(LANES), .PAIR(1'b0)) u_lanes_b (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_b),
    .want_i (plan.b_en),
    .leg_o  (b_clk),
    .oe_o   (b_oe)
  );

  fan_out_lanes #(.N(LANES), .PAIR(1'b1)) u_lanes_c (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_b),
    .want_i (plan.c_en),
    .leg_o  ({c_n, c_p}),
    .oe_o   (c_oe)
  );

  // Reference lane: same one-register delay as the banks, never gated.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= div_ref;
    end
  end

  assign ref_clk = ref_q;

endmodule

// File: rtl/clk_fanout_divider_chk.sv
module clk_fanout_divider_chk #(
  parameter int unsigned B_HALF      = 2,
  parameter int unsigned A_FAST_HALF = 5,
  parameter int unsigned A_SLOW_HALF = 10,
  parameter int unsigned REF_HALF    = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] a_clk,
  input logic [2:0] a_oe,
  input logic [2:0] b_clk,
  input logic [2:0] b_oe,
  input logic [2:0] c_p,
  input logic [2:0] c_n,
  input logic [2:0] c_oe,
  input logic       ref_clk
);

  logic        armed_q = 1'b0;
  logic [15:0] ref_hi;

  always_ff @(posedge clk) begin
    armed_q <= 1'b1;
    if (rst)          ref_hi <= '0;
    else if (ref_clk) ref_hi <= ref_hi + 1'b1;
    else              ref_hi <= '0;
  end

  // R5: forced levels while reset is held
  p_reset_levels_r5: assert property (@(posedge clk)
    (armed_q && $past(rst)) |-> (a_clk == 3'b000 && b_clk == 3'b000 && c_p == 3'b000
      && c_n == 3'b111 && !ref_clk && a_oe == 3'b111 && b_oe == 3'b111 && c_oe == 3'b111));

  // R6: complement leg tracks true leg
  p_pair_inverse_r6: assert property (@(posedge clk) disable iff (rst)
    c_n == ~c_p);

  // R3: reference high phase length
  p_ref_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_clk) |-> ref_hi == 16'(REF_HALF));

  generate
    for (genvar i = 0; i < 3; i++) begin : g_lane
      logic [15:0] a_hi;
      logic [15:0] b_hi;
      logic [15:0] c_hi;

      always_ff @(posedge clk) begin
        if (rst) begin
          a_hi <= '0;
          b_hi <= '0;
          c_hi <= '0;
        end else begin
          a_hi <= a_clk[i] ? a_hi + 1'b1 : '0;
          b_hi <= b_clk[i] ? b_hi + 1'b1 : '0;
          c_hi <= c_p[i]   ? c_hi + 1'b1 : '0;
        end
      end

      // R1: bank B and C high phase
      p_b_width_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(b_clk[i]) |-> b_hi == 16'(B_HALF));
      p_c_width_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(c_p[i]) |-> c_hi == 16'(B_HALF));

      // R2 and R7: bank A pulses are always a full phase of one rate
      p_a_width_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(a_clk[i]) |-> (a_hi == 16'(A_FAST_HALF) || a_hi == 16'(A_SLOW_HALF)));

      // R7: drive flags move only after a low data bit
      p_a_oe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (a_oe[i] != $past(a_oe[i])) |-> !$past(a_clk[i]));
      p_b_oe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (b_oe[i] != $past(b_oe[i])) |-> !$past(b_clk[i]));
      p_c_oe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (c_oe[i] != $past(c_oe[i])) |-> !$past(c_p[i]));
    end
  endgenerate

endmodule

bind clk_fanout_divider clk_fanout_divider_chk #(
  .B_HALF      (B_HALF),
  .A_FAST_HALF (A_FAST_HALF),
  .A_SLOW_HALF (A_SLOW_HALF),
  .REF_HALF    (REF_HALF)
) u_chk (.*);

// File: tb/clk_fanout_divider_bench.sv
module clk_fanout_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] oe_code = 3'b010;
  logic [2:0] a_clk, a_oe, b_clk, b_oe, c_p, c_n, c_oe;
  logic       ref_clk;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  clk_fanout_divider u_clk_fanout_divider (
    .clk     (clk),
    .rst     (rst),
    .oe_code (oe_code),
    .a_clk   (a_clk),
    .a_oe    (a_oe),
    .b_clk   (b_clk),
    .b_oe    (b_oe),
    .c_p     (c_p),
    .c_n     (c_n),
    .c_oe    (c_oe),
    .ref_clk (ref_clk)
  );

  wire [9:0] taps = {ref_clk, c_p, b_clk, a_clk};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {a_en[2:0], fast, b_en[2:0], c_en[2:0]} from the R4 table
  function automatic logic [9:0] exp_plan(input logic [2:0] code);
    case (code)
      3'b000: return {3'b001, 1'b0, 3'b000, 3'b001};
      3'b001: return {3'b001, 1'b0, 3'b001, 3'b001};
      3'b010: return {3'b011, 1'b0, 3'b000, 3'b011};
      3'b011: return {3'b111, 1'b0, 3'b111, 3'b111};
      3'b100: return {3'b001, 1'b1, 3'b000, 3'b001};
      3'b101: return {3'b011, 1'b0, 3'b011, 3'b011};
      3'b110: return {3'b011, 1'b1, 3'b000, 3'b011};
      default: return 10'd0;
    endcase
  endfunction

  // Pulse monitor for R6 and R7
  logic mon_en = 1'b0;
  int   run [10];
  int   mon_bad = 0;
  int   pair_bad = 0;

  always @(negedge clk) begin
    if (!rst && c_n !== ~c_p) pair_bad++;
    for (int i = 0; i < 10; i++) begin
      if (!mon_en) run[i] = 0;
      else if (taps[i]) run[i]++;
      else if (run[i] != 0) begin
        if (i < 3) begin
          if (run[i] != 5 && run[i] != 10) mon_bad++;
        end else if (i < 9) begin
          if (run[i] != 2) mon_bad++;
        end else begin
          if (run[i] != 10) mon_bad++;
        end
        run[i] = 0;
      end
    end
  end

  task automatic measure(input int idx, output int hi, output int per);
    int  t;
    int  lo;
    logic p;
    hi = -1; per = -1; t = 0;
    @(negedge clk);
    p = taps[idx];
    while (1) begin
      @(negedge clk);
      if (!p && taps[idx]) break;
      p = taps[idx];
      t++;
      if (t > 100) return;
    end
    hi = 1;
    while (1) begin
      @(negedge clk);
      if (!taps[idx]) break;
      hi++;
      if (hi > 100) return;
    end
    lo = 1;
    while (1) begin
      @(negedge clk);
      if (taps[idx]) break;
      lo++;
      if (lo > 100) return;
    end
    per = hi + lo;
  endtask

  task automatic check_reset_levels(input string tag);
    chk(a_clk == 3'b000 && b_clk == 3'b000 && c_p == 3'b000, {tag, " R5 data low"},
        int'({a_clk, b_clk, c_p}), 0);
    chk(c_n == 3'b111, {tag, " R5 complement high"}, int'(c_n), 7);
    chk(ref_clk == 1'b0, {tag, " R5 ref low"}, int'(ref_clk), 0);
    chk({a_oe, b_oe, c_oe} == 9'h1FF, {tag, " R5 flags high"}, int'({a_oe, b_oe, c_oe}), 511);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] pl;
    logic [8:0] en9;
    int hi, per, mb, pb, seen;
    int first [4];

    repeat (6) @(negedge clk);
    check_reset_levels("initial");
    rst = 1'b0;
    mon_en = 1'b1;

    for (int code = 0; code < 8; code++) begin
      @(negedge clk);
      oe_code = 3'(code);
      mb = mon_bad;
      pb = pair_bad;
      repeat (80) @(negedge clk);
      pl = exp_plan(3'(code));
      en9 = {pl[2:0], pl[5:3], pl[9:7]};
      chk(a_oe == pl[9:7], $sformatf("R4 code %0d a_oe", code), int'(a_oe), int'(pl[9:7]));
      chk(b_oe == pl[5:3], $sformatf("R4 code %0d b_oe", code), int'(b_oe), int'(pl[5:3]));
      chk(c_oe == pl[2:0], $sformatf("R4 code %0d c_oe", code), int'(c_oe), int'(pl[2:0]));
      for (int i = 0; i < 9; i++) begin
        if (en9[i]) begin
          measure(i, hi, per);
          if (i < 3) begin
            chk(hi == (pl[6] ? 5 : 10) && per == 2 * hi,
                $sformatf("R2 code %0d lane A%0d high/period", code, i), hi * 100 + per,
                pl[6] ? 510 : 1020);
          end else begin
            chk(hi == 2 && per == 4,
                $sformatf("R1 code %0d lane %0d high/period", code, i), hi * 100 + per, 204);
          end
        end
      end
      seen = 0;
      repeat (25) begin
        @(negedge clk);
        if ((taps[8:0] & ~en9) != 9'd0) seen++;
      end
      chk(seen == 0, $sformatf("R4 code %0d disabled lanes stay low", code), seen, 0);
      measure(9, hi, per);
      chk(hi == 10 && per == 20, $sformatf("R3 code %0d ref high/period", code), hi * 100 + per, 1020);
      chk(pair_bad == pb, $sformatf("R6 code %0d pair inverse", code), pair_bad - pb, 0);
      chk(mon_bad == mb, $sformatf("R7 code %0d pulse widths", code), mon_bad - mb, 0);
    end

    // R7: rapid code changes at many divider phases
    mb = mon_bad;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      oe_code = 3'((k * 5 + k / 3) % 8);
      repeat ((k % 7) + 1) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(mon_bad == mb, "R7 rapid code changes pulse widths", mon_bad - mb, 0);

    // R5 mid-run reset, then R8 common first edge
    oe_code = 3'b011;
    repeat (60) @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_levels("midrun");
    rst = 1'b0;
    for (int j = 0; j < 4; j++) first[j] = -1;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (first[0] < 0 && a_clk[0]) first[0] = n;
      if (first[1] < 0 && b_clk[0]) first[1] = n;
      if (first[2] < 0 && c_p[0])   first[2] = n;
      if (first[3] < 0 && ref_clk)  first[3] = n;
    end
    chk(first[0] == 2, "R8 first rise bank A", first[0], 2);
    chk(first[1] == 2, "R8 first rise bank B", first[1], 2);
    chk(first[2] == 2, "R8 first rise bank C", first[2], 2);
    chk(first[3] == 2, "R8 first rise ref", first[3], 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule